// File: doc/BRIEF.md
# PHY Ability and Pause Resolution Poller

This block runs an endless management-read loop against an external Ethernet PHY. It reads the basic status register, then the local advertisement register, then the link partner ability register, and starts over. From the status word it reports link, auto-negotiation completion, jabber and remote fault. When the link is up and negotiation has finished, it resolves the highest speed and duplex that both ends advertise. It also decides whether the MAC should obey received PAUSE frames.

Pause handling is set by two control inputs. A force input turns pause handling on whatever the partner advertises. A negotiate input turns it on only when full duplex was resolved and both ends advertise the PAUSE bit. The serial management engine is outside the block. Each read is a request that carries an address and stays asserted until the engine returns a one-cycle acknowledge with the 16-bit read data. All resolved outputs are written together, in a single update cycle after the third read, so they always agree with one another.

Top module: `phy_ability_poller`

## Requirements
- R1: Reads are requested at addresses 1, 4, 5 in that order and the order repeats forever. The request and its address stay steady until a cycle where the acknowledge is high.
- R2: After each loop the status outputs copy the address-1 word: link_up from bit 2, an_done from bit 5, remote_fault from bit 4 and jabber from bit 1.
- R3: With the link good, speed and duplex come from the highest bit set in both advertisement words (bits 8..5 of addresses 4 and 5). The order is bit 8 = 100 Mb/s full, bit 7 = 100 half, bit 6 = 10 full, bit 5 = 10 half. speed100=1 means 100 Mb/s and full_duplex=1 means full duplex.
- R4: With force_pause high, pause_en is set on a resolution, whatever the advertised bits are.
- R5: With force_pause low and negotiate_pause high, pause_en is 1 only if full duplex was resolved and bit 10 is set in both the address-4 and address-5 words.
- R6: With force_pause and negotiate_pause both low, pause_en resolves to 0.
- R7: "Link good" means bits 2 and 5 of the status word are both set. If the link is not good, speed100, full_duplex and pause_en keep their values and link_down goes to 1. Otherwise link_down goes to 0.
- R8: If the two advertisement words share no bit in 8..5, speed100, full_duplex and pause_en keep their previous values.
- R9: The outputs change only in the update cycle. They take their new values one clock after the acknowledge of the address-5 read, and they do not move during the reads.
- R10: Reset sets speed100, full_duplex, pause_en, link_up, an_done, jabber and remote_fault to 0, and link_down to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_pause | input | 1 | Enable pause handling unconditionally |
| negotiate_pause | input | 1 | Enable pause handling when negotiated |
| rd_req | output | 1 | Management read request |
| rd_addr | output | ADDR_W | PHY register address of the request |
| rd_ack | input | 1 | One-cycle read completion |
| rd_data | input | 16 | Read data, valid with rd_ack |
| link_up | output | 1 | Link status bit of last status read |
| an_done | output | 1 | Auto-negotiation complete |
| jabber | output | 1 | Jabber detected |
| remote_fault | output | 1 | Remote fault detected |
| speed100 | output | 1 | Resolved speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex, 1 = full |
| pause_en | output | 1 | Obey received PAUSE frames |
| link_down | output | 1 | Last loop found link or negotiation not good |

## Verification
If the loop position is wrong, it shows up at the next request. The address on rd_addr leaves the 1-4-5 order, or the request drops before its acknowledge. A bad capture register or a bad resolution shows on speed100, full_duplex or pause_en one clock after the third acknowledge of the loop. A hold that should not happen shows on the loop that follows a link-down or no-common-ability pass. The bench serves reads with varied latency and samples the outputs both in the middle of a loop and right after its update. That way an early update is told apart from a wrong result.

// File: rtl/phy_ability_poller.sv
module phy_ability_poller #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] REG_STATUS = 1,
  parameter logic [ADDR_W-1:0] REG_ADV = 4,
  parameter logic [ADDR_W-1:0] REG_PARTNER = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_pause,
  input  logic              negotiate_pause,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic              link_up,
  output logic              an_done,
  output logic              jabber,
  output logic              remote_fault,
  output logic              speed100,
  output logic              full_duplex,
  output logic              pause_en,
  output logic              link_down
);

  typedef enum logic [1:0] {S_STAT, S_ADV, S_LPA, S_UPD} st_t;
  st_t st;
  logic [15:0] stat_q, adv_q, lpa_q;
  logic [3:0]  common;
  logic        good, nx_spd, nx_fd, nx_pause, take;

  assign rd_req  = (st != S_UPD);
  assign rd_addr = (st == S_ADV) ? REG_ADV : (st == S_LPA) ? REG_PARTNER : REG_STATUS;
  assign take    = rd_req & rd_ack;
  assign good    = stat_q[2] & stat_q[5];
  assign common  = adv_q[8:5] & lpa_q[8:5];

  always_comb begin
    nx_spd = 1'b0;
    nx_fd  = 1'b0;
    if (common[3])      begin nx_spd = 1'b1; nx_fd = 1'b1; end
    else if (common[2]) begin nx_spd = 1'b1; nx_fd = 1'b0; end
    else if (common[1]) begin nx_spd = 1'b0; nx_fd = 1'b1; end
  end

  assign nx_pause = force_pause | (negotiate_pause & nx_fd & adv_q[10] & lpa_q[10]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_STAT;
      stat_q <= '0; adv_q <= '0; lpa_q <= '0;
      link_up <= 1'b0; an_done <= 1'b0; jabber <= 1'b0; remote_fault <= 1'b0;
      speed100 <= 1'b0; full_duplex <= 1'b0; pause_en <= 1'b0; link_down <= 1'b1;
    end else begin
      case (st)
        S_STAT: if (take) begin stat_q <= rd_data; st <= S_ADV; end
        S_ADV:  if (take) begin adv_q  <= rd_data; st <= S_LPA; end
        S_LPA:  if (take) begin lpa_q  <= rd_data; st <= S_UPD; end
        default: begin
          st           <= S_STAT;
          link_up      <= stat_q[2];
          an_done      <= stat_q[5];
          jabber       <= stat_q[1];
          remote_fault <= stat_q[4];
          link_down    <= ~good;
          if (good && common != 4'd0) begin
            speed100    <= nx_spd;
            full_duplex <= nx_fd;
            pause_en    <= nx_pause;
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr)); // R1
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack && rd_addr == REG_STATUS |=> rd_addr == REG_ADV); // R1
  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UPD && good && common != 4'd0 && force_pause |=> pause_en); // R4
  AST_DOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UPD && !good |=> link_down && $stable({speed100, full_duplex, pause_en})); // R7
  AST_NO_COMMON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_UPD && common == 4'd0 |=> $stable({speed100, full_duplex, pause_en})); // R8
  AST_UPDATE_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    st != S_UPD |=> $stable({speed100, full_duplex, pause_en, link_down, link_up})); // R9

endmodule

// File: tb/sim_phy_ability_poller.sv
module sim_phy_ability_poller;
  logic clk = 1'b0, rst_n = 1'b0, force_pause = 1'b0, negotiate_pause = 1'b0;
  logic rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic rd_req, link_up, an_done, jabber, remote_fault, speed100, full_duplex, pause_en, link_down;
  logic [4:0] rd_addr;
  int applied = 0, bad = 0;

  always #2 clk = ~clk;

  phy_ability_poller u0 (.clk(clk), .rst_n(rst_n), .force_pause(force_pause),
    .negotiate_pause(negotiate_pause), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .link_up(link_up), .an_done(an_done), .jabber(jabber),
    .remote_fault(remote_fault), .speed100(speed100), .full_duplex(full_duplex),
    .pause_en(pause_en), .link_down(link_down));

  // {force, negotiate, status, adv, partner, exp speed, exp fd, exp pause, exp down}
  localparam logic [53:0] VEC [12] = '{
    {2'b01, 16'h0024, 16'h05E0, 16'h05E0, 4'b1110},
    {2'b01, 16'h0024, 16'h05E0, 16'h01E0, 4'b1100},
    {2'b01, 16'h0024, 16'h04A0, 16'h04E0, 4'b1000},
    {2'b01, 16'h0024, 16'h0460, 16'h0440, 4'b0110},
    {2'b01, 16'h0024, 16'h0420, 16'h0420, 4'b0000},
    {2'b10, 16'h0024, 16'h0020, 16'h0020, 4'b0010},
    {2'b00, 16'h0024, 16'h05E0, 16'h05E0, 4'b1100},
    {2'b01, 16'h0004, 16'h0420, 16'h0420, 4'b1101},
    {2'b01, 16'h0020, 16'h0420, 16'h0420, 4'b1101},
    {2'b01, 16'h0036, 16'h0440, 16'h0440, 4'b0110},
    {2'b01, 16'h0024, 16'h0500, 16'h0420, 4'b0110},
    {2'b11, 16'h0024, 16'h0080, 16'h0080, 4'b1010}
  };
  localparam string TAG [12] = '{"R3 R5", "R5", "R3 R5", "R3 R5", "R3", "R4", "R6",
                                 "R7", "R7", "R2", "R8", "R4 R3"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic serve(input logic [4:0] a, input logic [15:0] d, input int lat);
    logic ok = 1'b1;
    if (!rd_req || rd_addr !== a) ok = 1'b0;
    for (int i = 0; i < lat; i++) begin
      @(posedge clk); @(negedge clk);
      if (!rd_req || rd_addr !== a) ok = 1'b0;
    end
    chk("R1 request/address", {2'b0, ok, rd_addr}, {2'b0, 1'b1, a});
    rd_ack = 1'b1; rd_data = d;
    @(posedge clk); @(negedge clk);
    rd_ack = 1'b0; rd_data = '0;
  endtask

  task automatic finish_update;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset", {speed100, full_duplex, pause_en, link_down, link_up, an_done, jabber, remote_fault},
        8'b0001_0000);
    rst_n = 1'b1;
    for (int v = 0; v < 12; v++) begin
      {force_pause, negotiate_pause} = VEC[v][53:52];
      serve(5'd1, VEC[v][51:36], v % 3);
      serve(5'd4, VEC[v][35:20], (v + 1) % 4);
      serve(5'd5, VEC[v][19:4], v % 2);
      finish_update();
      chk(TAG[v], {4'b0, speed100, full_duplex, pause_en, link_down}, {4'b0, VEC[v][3:0]});
      chk("R2 status bits", {4'b0, link_up, an_done, jabber, remote_fault},
          {4'b0, VEC[v][38], VEC[v][41], VEC[v][37], VEC[v][40]});
    end
    // R9: mid-loop outputs stay at the last resolution (100 half, pause on)
    force_pause = 1'b0; negotiate_pause = 1'b1;
    serve(5'd1, 16'h0024, 2);
    serve(5'd4, 16'h0440, 0);
    chk("R9 mid-loop hold", {4'b0, speed100, full_duplex, pause_en, link_down}, 8'b0000_1010);
    serve(5'd5, 16'h0440, 3);
    chk("R9 not before update", {4'b0, speed100, full_duplex, pause_en, link_down}, 8'b0000_1010);
    finish_update();
    chk("R9 update after third read", {4'b0, speed100, full_duplex, pause_en, link_down}, 8'b0000_0110);
    // R6 with common 100 full and both pause bits
    force_pause = 1'b0; negotiate_pause = 1'b0;
    serve(5'd1, 16'h0024, 0); serve(5'd4, 16'h0500, 0); serve(5'd5, 16'h0500, 0);
    finish_update();
    chk("R6 no pause when neither bit", {4'b0, speed100, full_duplex, pause_en, link_down}, 8'b0000_1100);
    // R10 reset in mid-loop returns to reset values and address 1
    serve(5'd1, 16'h0036, 0);
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    chk("R10 reset again", {speed100, full_duplex, pause_en, link_down, link_up, an_done, jabber, remote_fault},
        8'b0001_0000);
    serve(5'd1, 16'h0024, 1);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule